// File: doc/BRIEF.md
# Performance Counter Enable and Overflow Control

This block holds the run state of a small performance monitor with three event counters and one cycle counter. Software never writes the enable bits directly. It uses a set view, where every 1 written turns a counter on, and a clear view, where every 1 written turns a counter off. A global run bit in a control word gates every counter, the cycle counter included. The individual enables survive while the global bit is low, and they can still be read and edited. The block also keeps sticky overflow flags that the counters raise, and it reports the per-counter run signals that the counter datapath consumes.

Register accesses arrive as single-cycle strobes on a plain select/write/data bus that carries a privilege indicator. Privileged accesses always succeed. A user-mode access succeeds only when the user-access bit is set. A user-mode access that is refused changes nothing, returns zero and pulses a fault output. Read data comes back one cycle after the strobe, on a registered port. The bus has no back-pressure: each strobe is taken in the cycle it is presented, so no ready signal exists.

Top module: `pmu_enable_ctl`

## Requirements
- R1: Register select codes are: 0 control, 1 enable-set view, 2 enable-clear view, 3 overflow flags, 4 user-access. In the enable views and in the overflow word, bit 31 is the cycle counter and bits 2, 1 and 0 are event counters 2, 1 and 0. In `cnt_run` and `ovf_pulse`, index 3 is the cycle counter and indices 2..0 are the event counters.
- R2: Writing the enable-set view sets each enable whose data bit is 1 and leaves the others unchanged. Reading either enable view returns the current enable bits.
- R3: Writing the enable-clear view clears each enable whose data bit is 1 and leaves the others unchanged.
- R4: Bits 30..3 of the enable views and of the overflow word read as zero, and writes to them are ignored. Bits 31..1 of the control and user-access words read as zero.
- R5: Bit 0 of the control word is the global run bit. `cnt_run[i]` is high exactly when enable i and the global run bit are both set.
- R6: While the global run bit is clear, the enable bits keep their values, read back unchanged, and can still be set and cleared through the views.
- R7: An overflow flag is set by a pulse on its `ovf_pulse` line and stays set until a write of 1 to that flag's bit. When a pulse and a clear fall in the same cycle, the flag stays set.
- R8: A privileged access is always granted. A user-mode access is granted only when bit 0 of the user-access word is set. A user-mode access to the user-access word is never granted.
- R9: A refused access changes no register. If it is a read, it returns zero. In either case `acc_fault` is high for exactly the one cycle after the strobe.
- R10: After reset, all enables, all overflow flags, the global run bit and the user-access bit are zero.
- R11: `rd_valid` and `rd_data` answer a read strobe in the following cycle. A granted write is visible on `cnt_run` and in reads from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register select code |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | 1 = privileged access, 0 = user mode |
| ovf_pulse | input | 4 | Overflow pulses from the counters |
| cnt_run | output | 4 | Per-counter count enable |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| acc_fault | output | 1 | Refused-access pulse |

## Verification
Two functions can land on an overflow flag in the same cycle: a counter's overflow pulse and a software write that clears that flag. The bench forces this with a directed write of 1 to a flag while the same flag's pulse is driven. It also lets the random phase drive flag-clear writes together with random pulses on every line. The expected result is that the flag survives, and this is judged by reading the flag word back through the bus. A second collision, a refused user write to the clear view while the global bit is low, is judged by reading the enables back with a privileged access.

// File: rtl/pmu_ctl_pkg.sv
package pmu_ctl_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_EN_SET = 3'd1,
    SEL_EN_CLR = 3'd2,
    SEL_OVF    = 3'd3,
    SEL_USER   = 3'd4
  } pmu_sel_e;
endpackage

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
  import pmu_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [SEL_W-1:0] acc_addr,
  input  logic             acc_priv,
  input  logic             user_en,
  output logic             grant,
  output logic             wr_grant,
  output logic             acc_fault
);
  // The user-access word is reserved for privileged code.
  logic user_target_ok;
  assign user_target_ok = user_en && (acc_addr != SEL_USER);
  assign grant          = acc_priv || user_target_ok;
  assign wr_grant       = acc_valid && acc_write && grant;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_fault <= 1'b0;
    else        acc_fault <= acc_valid && !grant;
  end

  // R9: a fault only ever follows a user-mode strobe
  p_fault_from_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> $past(acc_valid && !acc_priv));
  // R8: privileged strobes never fault
  p_priv_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_priv) |=> !acc_fault);
endmodule

// File: rtl/pmu_enable_bank.sv
module pmu_enable_bank #(
  parameter int unsigned CNT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic [CNT-1:0] bits_in,
  output logic [CNT-1:0] en_q
);
  for (genvar i = 0; i < CNT; i++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)                    en_q[i] <= 1'b0;
      else if (set_we && bits_in[i]) en_q[i] <= 1'b1;
      else if (clr_we && bits_in[i]) en_q[i] <= 1'b0;
    end

    // R3: a 1 written to the clear view drops the enable
    p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && bits_in[i]) |=> !en_q[i]);
    // R2: a 1 written to the set view raises the enable
    p_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && bits_in[i]) |=> en_q[i]);
    // R2/R3: zero bits leave the enable alone
    p_zero_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_we || clr_we) && !bits_in[i]) |=> $stable(en_q[i]));
  end
endmodule

// File: rtl/pmu_overflow_flags.sv
module pmu_overflow_flags #(
  parameter int unsigned CNT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CNT-1:0] ovf_pulse,
  input  logic           clr_we,
  input  logic [CNT-1:0] bits_in,
  output logic [CNT-1:0] flag_q
);
  for (genvar i = 0; i < CNT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                    flag_q[i] <= 1'b0;
      else if (ovf_pulse[i])         flag_q[i] <= 1'b1;
      else if (clr_we && bits_in[i]) flag_q[i] <= 1'b0;
    end

    // R7: a pulse always leaves the flag set, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[i] |=> flag_q[i]);
    // R7: without a clear, a set flag stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(clr_we && bits_in[i])) |=> flag_q[i]);
  end
endmodule

// File: rtl/pmu_enable_ctl.sv
module pmu_enable_ctl
  import pmu_ctl_pkg::*;
#(
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned CYC_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [SEL_W-1:0]  acc_addr,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic              acc_priv,
  input  logic [NUM_EVT:0]  ovf_pulse,
  output logic [NUM_EVT:0]  cnt_run,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              acc_fault
);
  localparam int unsigned CNT = NUM_EVT + 1;

  logic           grant, wr_grant;
  logic           glob_en, user_en;
  logic [CNT-1:0] en_q, flag_q, wr_bits;
  logic           set_we, clr_we, ovf_we;

  // Compact the sparse word layout into one bit per counter.
  assign wr_bits = {acc_wdata[CYC_BIT], acc_wdata[NUM_EVT-1:0]};
  logic unused_rsvd;
  assign unused_rsvd = ^{acc_wdata[CYC_BIT-1:NUM_EVT]};

  function automatic logic [WORD_W-1:0] spread(input logic [CNT-1:0] v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CYC_BIT] = v[NUM_EVT];
    w[NUM_EVT-1:0] = v[NUM_EVT-1:0];
    return w;
  endfunction

  pmu_access_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_priv  (acc_priv),
    .user_en   (user_en),
    .grant     (grant),
    .wr_grant  (wr_grant),
    .acc_fault (acc_fault)
  );

  assign set_we = wr_grant && (acc_addr == SEL_EN_SET);
  assign clr_we = wr_grant && (acc_addr == SEL_EN_CLR);
  assign ovf_we = wr_grant && (acc_addr == SEL_OVF);

  pmu_enable_bank #(.CNT(CNT)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_we  (set_we),
    .clr_we  (clr_we),
    .bits_in (wr_bits),
    .en_q    (en_q)
  );

  pmu_overflow_flags #(.CNT(CNT)) u_ovf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_pulse (ovf_pulse),
    .clr_we    (ovf_we),
    .bits_in   (wr_bits),
    .flag_q    (flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      user_en <= 1'b0;
    end else if (wr_grant) begin
      if (acc_addr == SEL_CTRL) glob_en <= acc_wdata[0];
      if (acc_addr == SEL_USER) user_en <= acc_wdata[0];
    end
  end

  assign cnt_run = glob_en ? en_q : '0;

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (acc_addr)
      SEL_CTRL:   rd_mux[0] = glob_en;
      SEL_EN_SET,
      SEL_EN_CLR: rd_mux = spread(en_q);
      SEL_OVF:    rd_mux = spread(flag_q);
      SEL_USER:   rd_mux[0] = user_en;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      rd_data  <= (acc_valid && !acc_write && grant) ? rd_mux : '0;
    end
  end

  // R4: reserved read bits are always zero
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[CYC_BIT-1:NUM_EVT] == '0));
  // R9: a refused access leaves enables and control unchanged
  p_denied_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> ($stable(en_q) && $stable(glob_en) && $stable(user_en)));
  // R9: a refused read returns zero
  p_denied_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fault && rd_valid) |-> (rd_data == '0));
endmodule

// File: tb/pmu_enable_ctl_bench.sv
module pmu_enable_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [3:0]  ovf_pulse = '0;
  logic [3:0]  cnt_run;
  logic        rd_valid, acc_fault;
  logic [31:0] rd_data;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // Bench model of the register state.
  logic [3:0] m_en = '0, m_ovf = '0;
  logic       m_glob = 1'b0, m_uen = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pmu_enable_ctl u_pmu_enable_ctl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
    .ovf_pulse(ovf_pulse), .cnt_run(cnt_run), .rd_valid(rd_valid),
    .rd_data(rd_data), .acc_fault(acc_fault)
  );

  function automatic logic [31:0] to_word(input logic [3:0] v);
    logic [31:0] w = '0;
    w[31] = v[3];
    w[2:0] = v[2:0];
    return w;
  endfunction

  function automatic logic [3:0] from_word(input logic [31:0] w);
    return {w[31], w[2:0]};
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_glob};
      3'd1, 3'd2: return to_word(m_en);
      3'd3: return to_word(m_ovf);
      3'd4: return {31'd0, m_uen};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample 1 ns after the posedge.
  task automatic step(input logic v, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic p, input logic [3:0] pl,
                      input string tag);
    logic ok, e_rv, e_flt;
    logic [31:0] e_rd;
    logic [3:0] bits;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
    acc_priv = p; ovf_pulse = pl;
    @(posedge clk);
    #1;
    ok    = p || (m_uen && a != 3'd4);
    e_rv  = v && !w;
    e_flt = v && !ok;
    e_rd  = (v && !w && ok) ? model_read(a) : 32'd0;
    bits  = from_word(d);
    if (v && w && ok) begin
      case (a)
        3'd0: m_glob = d[0];
        3'd1: m_en = m_en | bits;
        3'd2: m_en = m_en & ~bits;
        3'd3: m_ovf = m_ovf & ~bits;
        3'd4: m_uen = d[0];
        default: ;
      endcase
    end
    m_ovf = m_ovf | pl;
    check(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, e_rv});
    check(tag, "acc_fault", {31'd0, acc_fault}, {31'd0, e_flt});
    if (e_rv) check(tag, "rd_data", rd_data, e_rd);
    check(tag, "cnt_run", {28'd0, cnt_run}, {28'd0, (m_glob ? m_en : 4'd0)});
    acc_valid = 1'b0;
    ovf_pulse = '0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(1, 0, a, 32'd0, 1, 4'd0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 1, 4'd0, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state read back through the bus
    for (int a = 0; a < 5; a++) rd(3'(a), "R10");
    // R1 R4: set every bit; only 31 and 2..0 hold
    wr(3'd1, 32'hFFFF_FFFF, "R1");
    rd(3'd1, "R4");
    rd(3'd2, "R2");
    // R5: global bit gates the run outputs
    wr(3'd0, 32'h1, "R5");
    // R3: clear event counter 1 only; zero bits keep their state
    wr(3'd2, 32'h0000_0002, "R3");
    rd(3'd1, "R3");
    // R11: set view with zeros changes nothing
    wr(3'd1, 32'h0, "R11");
    // R6: global off, enables retained and still clearable
    wr(3'd0, 32'h0, "R6");
    rd(3'd2, "R6");
    wr(3'd2, 32'h8000_0000, "R6");
    rd(3'd1, "R6");
    wr(3'd1, 32'h8000_0000, "R6");
    // R7: pulse then clear; pulse against a clear on the same bit
    step(0, 0, 3'd0, 32'd0, 1, 4'b1001, "R7");
    rd(3'd3, "R7");
    step(1, 1, 3'd3, 32'h8000_0001, 1, 4'b0001, "R7");
    rd(3'd3, "R7");
    wr(3'd3, 32'h0000_0001, "R7");
    rd(3'd3, "R7");
    // R8 R9: user mode without permission is refused
    step(1, 1, 3'd2, 32'hFFFF_FFFF, 0, 4'd0, "R9");
    step(1, 0, 3'd1, 32'd0, 0, 4'd0, "R9");
    rd(3'd1, "R9");
    wr(3'd4, 32'h1, "R8");
    step(1, 1, 3'd1, 32'h0000_0004, 0, 4'd0, "R8");
    step(1, 0, 3'd1, 32'd0, 0, 4'd0, "R8");
    step(1, 1, 3'd4, 32'h0, 0, 4'd0, "R8");
    rd(3'd4, "R8");
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom % 6);
      d = $urandom;
      if (($urandom % 4) == 0) d = d & 32'h8000_0007;
      step(($urandom % 4) != 0, $urandom % 2, a, d, ($urandom % 3) != 0,
           (($urandom % 3) == 0) ? 4'($urandom) : 4'd0, "R2");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule